// File: doc/BRIEF.md
# Reset, Interrupt and Standby Controller

This block sits between the control pins of a small 8-bit microcontroller and its core. It filters the active-low reset pin, so that only a pulse lasting a minimum number of machine cycles resets the core. It turns the active-low external interrupt pin and a timer request into a level-sensitive interrupt request with a vector select. It drives the oscillator clock-enable through a standby mode and a wake-up sequence, and it holds the core after each instruction fetch while single-step is selected.

All pins pass through two-flop synchronisers clocked by `clk_i`, a clock that never stops. A free-running divider of `CYC_CLKS` clocks marks machine-cycle boundaries. The reset filter counts these boundaries, and the interrupt request is re-evaluated at each one. The core tells the block when it enables or disables interrupts, when it takes an interrupt, when it returns from one, and when an instruction fetch ends. `arst_ni` is the block's own power-on clear. In that state the core reset is asserted until the first clock edge.

Top module: `rst_int_stby_ctl`

## Requirements
- R1: When the synchronised reset pin is sampled low at `RST_MIN_CYC` (default 2) consecutive machine-cycle boundaries, `core_rst_o` goes to 1 and stays there while the pin is low. It returns to 0 within 3 clocks of the pin going high.
- R2: A reset pin low pulse shorter than one machine cycle never asserts `core_rst_o`.
- R3: While `core_rst_o` is 1, the interrupt enable and the in-service flag are cleared and `irq_o` is 0. This also holds when `int_en_set_i` is pulsed in the same cycle, so after the reset ends a low interrupt pin raises no request.
- R4: With interrupts enabled and the interrupt pin low, `irq_o` becomes 1 at the next machine-cycle boundary, with `irq_vec_o` = 0 (external). With interrupts disabled, a low pin gives no request.
- R5: `int_level_o` is 1 exactly when the synchronised interrupt pin is low, whatever the enable state.
- R6: `int_ack_i` clears `irq_o` on the next clock. No new request is raised until `reti_i` is pulsed; after that, a pin that is still low requests again.
- R7: `timer_req_i` raises `irq_o` with `irq_vec_o` = 1 (timer). When both sources request at once, the external one wins and `irq_vec_o` = 0.
- R8: A low standby pin, synchronised, takes `clk_en_o` to 0 on the next clock.
- R9: Standby ends only when the standby pin is high and the interrupt pin or the reset pin is low. A low interrupt pin while standby is still held low does not wake the block, and neither does a high standby pin alone.
- R10: If the single-step pin is low when a wake-up occurs, `clk_en_o` stays 0 until that pin goes high.
- R11: `fetch_done_i` with the single-step pin low sets `step_hold_o` on the next clock. It stays set until the single-step pin rises. With the single-step pin high, `fetch_done_i` leaves it at 0.
- R12: After power-on with all pins high, `core_rst_o`, `irq_o` and `step_hold_o` are 0 and `clk_en_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running block clock |
| arst_ni | input | 1 | Power-on clear, active low, asynchronous |
| rst_pin_ni | input | 1 | Reset pin, active low |
| int_pin_ni | input | 1 | External interrupt pin, active low |
| ss_pin_ni | input | 1 | Single-step pin, active low |
| stby_pin_ni | input | 1 | Standby-control pin; low stops the oscillator |
| timer_req_i | input | 1 | Timer interrupt request level |
| int_en_set_i | input | 1 | Core enables external interrupts (pulse) |
| int_en_clr_i | input | 1 | Core disables external interrupts (pulse) |
| int_ack_i | input | 1 | Core takes the interrupt (pulse) |
| reti_i | input | 1 | Core executes return-from-interrupt (pulse) |
| fetch_done_i | input | 1 | Core ends an instruction fetch (pulse) |
| core_rst_o | output | 1 | Reset to the core, active high |
| irq_o | output | 1 | Interrupt request |
| irq_vec_o | output | 1 | Vector select: 0 external, 1 timer |
| int_level_o | output | 1 | Interrupt pin asserted, for the jump-on-interrupt test |
| clk_en_o | output | 1 | Oscillator gate enable |
| step_hold_o | output | 1 | Stall the core at the end of a fetch |

## Verification
The collision of interest is a reset acceptance that coincides with interrupt handling. The bench raises a pending external request, then holds reset long enough for it to be accepted. While `core_rst_o` is high it pulses `int_en_set_i`, so that an enable request and the reset act in the same clock. The outcome is judged at the ports: `irq_o` must drop during the reset, and after release a still-low interrupt pin must raise no request, which shows that the reset cleared the enable. A second overlap is covered in standby: a short reset pulse, too brief to reach the core, still has to serve as a wake-up event.

// File: rtl/rst_int_stby_ctl.sv
module rst_int_stby_ctl #(
  parameter int CYC_CLKS    = 15,
  parameter int RST_MIN_CYC = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic rst_pin_ni,
  input  logic int_pin_ni,
  input  logic ss_pin_ni,
  input  logic stby_pin_ni,
  input  logic timer_req_i,
  input  logic int_en_set_i,
  input  logic int_en_clr_i,
  input  logic int_ack_i,
  input  logic reti_i,
  input  logic fetch_done_i,
  output logic core_rst_o,
  output logic irq_o,
  output logic irq_vec_o,
  output logic int_level_o,
  output logic clk_en_o,
  output logic step_hold_o
);

  localparam int CW = (CYC_CLKS > 1) ? $clog2(CYC_CLKS) : 1;
  localparam int RW = $clog2(RST_MIN_CYC + 1);
  localparam logic [CW-1:0] CYC_LAST = CW'(CYC_CLKS - 1);
  localparam logic [RW-1:0] RST_DONE = RW'(RST_MIN_CYC);

  typedef enum logic [1:0] {M_RUN, M_STBY, M_HOLD} mode_e;

  logic [1:0] rst_sy, int_sy, ss_sy, stby_sy;
  logic rst_s, int_s, ss_s, stby_s, ss_d, ss_rise;
  logic [CW-1:0] cyc_q;
  logic tick;
  logic [RW-1:0] rcnt_q;
  logic core_rst_q, int_en_q, in_svc_q, irq_q, vec_q, hold_q;
  mode_e mode_q;

  always_ff @(posedge clk_i or negedge arst_ni)
    if (!arst_ni) begin
      rst_sy <= 2'b11; int_sy <= 2'b11; ss_sy <= 2'b11; stby_sy <= 2'b11; ss_d <= 1'b1;
    end else begin
      rst_sy  <= {rst_sy[0], rst_pin_ni};
      int_sy  <= {int_sy[0], int_pin_ni};
      ss_sy   <= {ss_sy[0], ss_pin_ni};
      stby_sy <= {stby_sy[0], stby_pin_ni};
      ss_d    <= ss_sy[1];
    end

  assign rst_s   = rst_sy[1];
  assign int_s   = int_sy[1];
  assign ss_s    = ss_sy[1];
  assign stby_s  = stby_sy[1];
  assign ss_rise = ss_s & ~ss_d;
  assign tick    = (cyc_q == CYC_LAST);

  always_ff @(posedge clk_i or negedge arst_ni)
    if (!arst_ni)  cyc_q <= '0;
    else if (tick) cyc_q <= '0;
    else           cyc_q <= cyc_q + 1'b1;

  always_ff @(posedge clk_i or negedge arst_ni)
    if (!arst_ni) begin
      rcnt_q <= '0; core_rst_q <= 1'b1;
    end else if (rst_s) begin
      rcnt_q <= '0; core_rst_q <= 1'b0;
    end else begin
      if (tick && rcnt_q != RST_DONE) rcnt_q <= rcnt_q + 1'b1;
      core_rst_q <= (rcnt_q == RST_DONE);
    end

  always_ff @(posedge clk_i or negedge arst_ni)
    if (!arst_ni) begin
      int_en_q <= 1'b0; in_svc_q <= 1'b0; irq_q <= 1'b0; vec_q <= 1'b0;
    end else if (core_rst_q) begin
      int_en_q <= 1'b0; in_svc_q <= 1'b0; irq_q <= 1'b0; vec_q <= 1'b0;
    end else begin
      if (int_en_set_i)      int_en_q <= 1'b1;
      else if (int_en_clr_i) int_en_q <= 1'b0;
      if (int_ack_i) begin
        in_svc_q <= 1'b1; irq_q <= 1'b0;
      end else begin
        if (reti_i) in_svc_q <= 1'b0;
        if (tick) begin
          irq_q <= !in_svc_q && ((int_en_q && !int_s) || timer_req_i);
          vec_q <= !(int_en_q && !int_s);
        end
      end
    end

  always_ff @(posedge clk_i or negedge arst_ni)
    if (!arst_ni) mode_q <= M_RUN;
    else
      case (mode_q)
        M_RUN:  if (!stby_s) mode_q <= M_STBY;
        M_STBY: if (stby_s && (!int_s || !rst_s)) mode_q <= ss_s ? M_RUN : M_HOLD;
        M_HOLD: if (ss_s) mode_q <= M_RUN;
        default: mode_q <= M_RUN;
      endcase

  always_ff @(posedge clk_i or negedge arst_ni)
    if (!arst_ni)                   hold_q <= 1'b0;
    else if (core_rst_q || ss_rise) hold_q <= 1'b0;
    else if (fetch_done_i && !ss_s) hold_q <= 1'b1;

  assign core_rst_o  = core_rst_q;
  assign irq_o       = irq_q;
  assign irq_vec_o   = vec_q;
  assign int_level_o = ~int_s;
  assign clk_en_o    = (mode_q == M_RUN);
  assign step_hold_o = hold_q;

  AST_RST_ACCEPT: assert property (@(posedge clk_i) disable iff (!arst_ni)
    $rose(core_rst_o) |-> !$past(rst_s)); // R1
  AST_RST_RELEASE: assert property (@(posedge clk_i) disable iff (!arst_ni)
    rst_s |=> !core_rst_o); // R1
  AST_RST_MASK: assert property (@(posedge clk_i) disable iff (!arst_ni)
    core_rst_o |=> (!irq_o && !int_en_q)); // R3
  AST_ACK_DROP: assert property (@(posedge clk_i) disable iff (!arst_ni)
    int_ack_i |=> !irq_o); // R6
  AST_STBY_ENTER: assert property (@(posedge clk_i) disable iff (!arst_ni)
    (mode_q == M_RUN && !stby_s) |=> !clk_en_o); // R8
  AST_WAKE_HOLD: assert property (@(posedge clk_i) disable iff (!arst_ni)
    (mode_q == M_STBY && stby_s && !int_s && !ss_s) |=> !clk_en_o); // R10
  AST_STEP_SET: assert property (@(posedge clk_i) disable iff (!arst_ni)
    (fetch_done_i && !ss_s && !core_rst_o) |=> step_hold_o); // R11

endmodule

// File: tb/rst_int_stby_ctl_tb.sv
module rst_int_stby_ctl_tb;
  localparam int MC = 5;

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic rst_n = 1'b1, int_n = 1'b1, ss_n = 1'b1, stby_n = 1'b1;
  logic tmr = 1'b0, en_set = 1'b0, en_clr = 1'b0, ack = 1'b0, reti = 1'b0, fdone = 1'b0;
  logic core_rst, irq, vec, ilev, clk_en, hold;
  int checks = 0, failures = 0;
  bit done = 1'b0, seen_rst = 1'b0;

  always #10 clk = ~clk;

  rst_int_stby_ctl #(.CYC_CLKS(MC), .RST_MIN_CYC(2)) u_dut (
    .clk_i(clk), .arst_ni(arst_n), .rst_pin_ni(rst_n), .int_pin_ni(int_n),
    .ss_pin_ni(ss_n), .stby_pin_ni(stby_n), .timer_req_i(tmr),
    .int_en_set_i(en_set), .int_en_clr_i(en_clr), .int_ack_i(ack), .reti_i(reti),
    .fetch_done_i(fdone), .core_rst_o(core_rst), .irq_o(irq), .irq_vec_o(vec),
    .int_level_o(ilev), .clk_en_o(clk_en), .step_hold_o(hold));

  always @(negedge clk) if (core_rst) seen_rst <= 1'b1;

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; wt(1); s = 1'b0;
  endtask

  task automatic t_power_on;
    wt(3); arst_n = 1'b1; wt(4);
    chk("R12 core_rst", core_rst, 1'b0);
    chk("R12 irq", irq, 1'b0);
    chk("R12 hold", hold, 1'b0);
    chk("R12 clk_en", clk_en, 1'b1);
  endtask

  task automatic t_reset_filter;
    seen_rst = 1'b0;
    rst_n = 1'b0; wt(MC - 1); rst_n = 1'b1; wt(MC * 3);
    chk("R2 short pulse ignored", seen_rst, 1'b0);
    rst_n = 1'b0; wt(4 * MC);
    chk("R1 long pulse accepted", core_rst, 1'b1);
    rst_n = 1'b1; wt(4);
    chk("R1 release", core_rst, 1'b0);
  endtask

  task automatic t_interrupts;
    int_n = 1'b0; wt(MC + 4);
    chk("R4 disabled no irq", irq, 1'b0);
    chk("R5 level while disabled", ilev, 1'b1);
    pulse(en_set); wt(MC + 3);
    chk("R4 enabled irq", irq, 1'b1);
    chk("R4 external vector", vec, 1'b0);
    pulse(ack); wt(1);
    chk("R6 ack drops irq", irq, 1'b0);
    wt(2 * MC);
    chk("R6 blocked in service", irq, 1'b0);
    pulse(reti); wt(MC + 2);
    chk("R6 re-request after reti", irq, 1'b1);
    tmr = 1'b1; wt(MC + 2);
    chk("R7 external wins", vec, 1'b0);
    int_n = 1'b1; wt(MC + 4);
    chk("R5 level released", ilev, 1'b0);
    chk("R7 timer irq", irq, 1'b1);
    chk("R7 timer vector", vec, 1'b1);
    tmr = 1'b0; pulse(en_clr); int_n = 1'b0; wt(MC + 4);
    chk("R4 disabled again", irq, 1'b0);
    int_n = 1'b1; wt(4);
  endtask

  task automatic t_reset_vs_irq;
    pulse(en_set); int_n = 1'b0; wt(MC + 4);
    chk("R4 pending before reset", irq, 1'b1);
    rst_n = 1'b0; wt(4 * MC);
    en_set = 1'b1; wt(1); en_set = 1'b0; wt(1);
    chk("R3 core_rst held", core_rst, 1'b1);
    chk("R3 irq masked", irq, 1'b0);
    rst_n = 1'b1; wt(2 * MC + 4);
    chk("R3 enable cleared", irq, 1'b0);
    int_n = 1'b1; wt(4);
  endtask

  task automatic t_standby;
    stby_n = 1'b0; wt(4);
    chk("R8 standby stops clock", clk_en, 1'b0);
    int_n = 1'b0; wt(4);
    chk("R9 int while stby low", clk_en, 1'b0);
    int_n = 1'b1; wt(3); stby_n = 1'b1; wt(4);
    chk("R9 stby high alone", clk_en, 1'b0);
    int_n = 1'b0; wt(4);
    chk("R9 int wakes", clk_en, 1'b1);
    int_n = 1'b1; ss_n = 1'b0; stby_n = 1'b0; wt(4);
    stby_n = 1'b1; wt(3);
    rst_n = 1'b0; wt(2); rst_n = 1'b1; wt(4);
    chk("R10 ss low holds clock", clk_en, 1'b0);
    ss_n = 1'b1; wt(4);
    chk("R10 ss high restarts", clk_en, 1'b1);
  endtask

  task automatic t_single_step;
    ss_n = 1'b0; wt(4);
    pulse(fdone); wt(1);
    chk("R11 hold set", hold, 1'b1);
    wt(5);
    chk("R11 hold kept", hold, 1'b1);
    ss_n = 1'b1; wt(4);
    chk("R11 released on ss rise", hold, 1'b0);
    pulse(fdone); wt(2);
    chk("R11 no hold with ss high", hold, 1'b0);
  endtask

  initial begin
    t_power_on;
    t_reset_filter;
    t_interrupts;
    t_reset_vs_irq;
    t_standby;
    t_single_step;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule